// File: doc/BRIEF.md
# NRU Way Replacement Selector

This block holds the replacement state of a set-associative cache that uses a not-recently-used policy. Every set owns one usage bit per way. A hit strobe names a set and a way and marks that way as used. A fill strobe marks the way that was just loaded in the same manner. Once a set has every one of its ways marked, the whole set is wiped back to unmarked in that same update.

A cache controller asks for a victim by presenting a set index on the query port. One cycle later the block returns the lowest-numbered way of that set whose usage bit is clear, together with a valid flag. The tag store, the data arrays and the controller's own sequencing sit outside this block. The number of sets and the number of ways are parameters.

Top module: `nru_repl_sel`

## Requirements
- R1: After reset every usage bit is clear, so a query to any set returns way 0 with the valid flag high.
- R2: A hit strobe (`hit_vld` with `hit_set`, `hit_way`) marks that way, and a later query of that set no longer returns it, unless the mark completed the set.
- R3: When an update would leave every way of a set marked, all bits of that set are cleared instead, and a following query of that set returns way 0.
- R4: The returned victim is the lowest way index whose usage bit is clear. Every lower index is marked.
- R5: A fill strobe (`fill_vld` with `fill_set`, `fill_way`) marks its way exactly as a hit strobe does, including the clear-all rule.
- R6: A query and an update to the same set in the same cycle see the state from before that update. The update is visible to queries from the next cycle on.
- R7: `vic_vld` is high in the cycle after a cycle with `ask_vld` high, and low otherwise. `vic_way` carries the victim in that cycle.
- R8: Updates to one set leave the usage bits of every other set unchanged.
- R9: A hit and a fill to the same set in one cycle both apply. If together they complete the set, the set is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_vld | input | 1 | Hit strobe |
| hit_set | input | SET_W | Set index of the hit |
| hit_way | input | WAY_W | Way index of the hit |
| fill_vld | input | 1 | Fill strobe |
| fill_set | input | SET_W | Set index of the fill |
| fill_way | input | WAY_W | Way index that was filled |
| ask_vld | input | 1 | Victim query strobe |
| ask_set | input | SET_W | Set index being queried |
| vic_vld | output | 1 | Victim result valid, one cycle after a query |
| vic_way | output | WAY_W | Way chosen for replacement |

## Verification
The selector is driven with directed sequences on separate sets. These cover marking ways out of order, so that the lowest-clear scan is separated from plain counting. They cover filling every way, so that the clear-all wipe is separated from the case where a set is left fully marked. They also cover a query that coincides with an update to the same set, so that the pre-update view is separated from a bypassed one. Hits and fills that complete a set together test whether both sources merge before the wipe. A long pseudo-random stream over sixteen sets, with mixed hits, fills and queries, compares every victim against a reference model kept in the bench. This also exposes any leakage of state between sets.

// File: rtl/nru_pkg.sv
package nru_pkg;

   // Upper bound on associativity handled by the selector
   localparam int unsigned NRU_MAX_WAYS = 64;

   // Index width for n items, never below one bit
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/nru_set_row.sv
module nru_set_row #(
   parameter int unsigned WAYS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [WAYS-1:0] mark,
   output logic [WAYS-1:0] used
);

   logic [WAYS-1:0] merged;
   logic [WAYS-1:0] nxt;

   always_comb begin
      merged = used | mark;
      nxt    = (&merged) ? '0 : merged;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      used <= '0;
      else if (|mark)  used <= nxt;
   end

endmodule

// File: rtl/nru_victim_pick.sv
module nru_victim_pick #(
   parameter int unsigned WAYS  = 8,
   parameter int unsigned WAY_W = 3
) (
   input  logic [WAYS-1:0]  used,
   output logic             found,
   output logic [WAY_W-1:0] way
);

   always_comb begin
      found = 1'b0;
      way   = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (!used[i]) begin
            found = 1'b1;
            way   = WAY_W'(i);
         end
      end
   end

endmodule

// File: rtl/nru_repl_sel.sv
module nru_repl_sel #(
   parameter int unsigned SETS  = 256,
   parameter int unsigned WAYS  = 8,
   parameter int unsigned SET_W = nru_pkg::idx_bits(SETS),
   parameter int unsigned WAY_W = nru_pkg::idx_bits(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_vld,
   input  logic [SET_W-1:0] hit_set,
   input  logic [WAY_W-1:0] hit_way,
   input  logic             fill_vld,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way,
   input  logic             ask_vld,
   input  logic [SET_W-1:0] ask_set,
   output logic             vic_vld,
   output logic [WAY_W-1:0] vic_way
);

   localparam int unsigned ROWS = 1 << SET_W;

   if (WAYS < 2 || WAYS > nru_pkg::NRU_MAX_WAYS) begin : g_bad_ways
      $error("nru_repl_sel: WAYS out of range");
   end
   if (SETS != ROWS) begin : g_bad_sets
      $error("nru_repl_sel: SETS must be a power of two");
   end

   logic [WAYS-1:0] hit_oh;
   logic [WAYS-1:0] fill_oh;
   logic [WAYS-1:0] rows [ROWS];
   logic [WAYS-1:0] qrow;
   logic            pick_found;
   logic [WAY_W-1:0] pick_way;

   always_comb begin
      hit_oh  = '0;
      fill_oh = '0;
      for (int w = 0; w < WAYS; w++) begin
         hit_oh[w]  = hit_vld  && (hit_way  == WAY_W'(w));
         fill_oh[w] = fill_vld && (fill_way == WAY_W'(w));
      end
   end

   for (genvar s = 0; s < ROWS; s++) begin : g_row
      logic [WAYS-1:0] mark;
      always_comb begin
         mark = '0;
         if (hit_set  == SET_W'(s)) mark = mark | hit_oh;
         if (fill_set == SET_W'(s)) mark = mark | fill_oh;
      end
      nru_set_row #(.WAYS(WAYS)) u_row (
         .clk  (clk),
         .rst_n(rst_n),
         .mark (mark),
         .used (rows[s])
      );
   end

   assign qrow = rows[ask_set];

   nru_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
      .used (qrow),
      .found(pick_found),
      .way  (pick_way)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vic_vld <= 1'b0;
         vic_way <= '0;
      end else begin
         vic_vld <= ask_vld && pick_found;
         if (ask_vld) vic_way <= pick_way;
      end
   end

endmodule

// File: rtl/nru_repl_chk.sv
module nru_repl_chk #(
   parameter int unsigned WAYS  = 8,
   parameter int unsigned WAY_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ask_vld,
   input logic [WAYS-1:0]  qrow,
   input logic             vic_vld,
   input logic [WAY_W-1:0] vic_way
);

   logic [WAYS-1:0] below;
   assign below = (WAYS'(1) << vic_way) - WAYS'(1);

   // R7
   valid_after_ask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ask_vld |=> vic_vld);

   // R7
   no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ask_vld |=> !vic_vld);

   // R4
   victim_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vic_vld |-> ((($past(qrow) >> vic_way) & WAYS'(1)) == WAYS'(0)));

   // R4
   lower_all_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vic_vld |-> (($past(qrow) & below) == below));

   // R3
   never_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&qrow));

   // R4
   way_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vic_vld |-> (int'(vic_way) < int'(WAYS)));

endmodule

bind nru_repl_sel nru_repl_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ask_vld(ask_vld),
   .qrow   (qrow),
   .vic_vld(vic_vld),
   .vic_way(vic_way)
);

// File: tb/tb_nru_repl_sel.sv
module tb_nru_repl_sel;

   localparam int SETS  = 256;
   localparam int WAYS  = 8;
   localparam int SET_W = 8;
   localparam int WAY_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             hit_vld = 1'b0;
   logic [SET_W-1:0] hit_set = '0;
   logic [WAY_W-1:0] hit_way = '0;
   logic             fill_vld = 1'b0;
   logic [SET_W-1:0] fill_set = '0;
   logic [WAY_W-1:0] fill_way = '0;
   logic             ask_vld = 1'b0;
   logic [SET_W-1:0] ask_set = '0;
   logic             vic_vld;
   logic [WAY_W-1:0] vic_way;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [WAYS-1:0] mdl [SETS];
   int    exp_q [$];
   string tag_q [$];

   always #4 clk = ~clk;

   nru_repl_sel #(.SETS(SETS), .WAYS(WAYS)) dut (
      .clk(clk), .rst_n(rst_n),
      .hit_vld(hit_vld), .hit_set(hit_set), .hit_way(hit_way),
      .fill_vld(fill_vld), .fill_set(fill_set), .fill_way(fill_way),
      .ask_vld(ask_vld), .ask_set(ask_set),
      .vic_vld(vic_vld), .vic_way(vic_way)
   );

   function automatic int first_clear(input logic [WAYS-1:0] v);
      for (int i = 0; i < WAYS; i++) if (!v[i]) return i;
      return -1;
   endfunction

   task automatic step(input bit h, input int hs, input int hw,
                       input bit f, input int fs, input int fw,
                       input bit a, input int as_, input string tag);
      logic [WAYS-1:0] m;
      @(negedge clk);
      hit_vld  = h;  hit_set  = SET_W'(hs); hit_way  = WAY_W'(hw);
      fill_vld = f;  fill_set = SET_W'(fs); fill_way = WAY_W'(fw);
      ask_vld  = a;  ask_set  = SET_W'(as_);
      if (a) begin
         exp_q.push_back(first_clear(mdl[as_]));
         tag_q.push_back(tag);
      end
      if (h) begin
         m = mdl[hs] | (WAYS'(1) << hw);
         if (f && fs == hs) m = m | (WAYS'(1) << fw);
         mdl[hs] = (&m) ? '0 : m;
      end
      if (f && !(h && fs == hs)) begin
         m = mdl[fs] | (WAYS'(1) << fw);
         mdl[fs] = (&m) ? '0 : m;
      end
   endtask

   task automatic hit(input int s, input int w);
      step(1, s, w, 0, 0, 0, 0, 0, "");
   endtask

   task automatic ask(input int s, input string tag);
      step(0, 0, 0, 0, 0, 0, 1, s, tag);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   // Monitor: compares each result against the scoreboard queue
   always @(posedge clk) begin
      #2;
      if (rst_n && (vic_vld || exp_q.size() != 0)) begin
         total++;
         if (!vic_vld) begin
            bad++;
            $display("FAIL R7 vic_vld actual=0 expected=1 (%s)", tag_q[0]);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end else if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R7 vic_vld actual=1 expected=0");
         end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (int'(vic_way) != e) begin
               bad++;
               $display("FAIL %s vic_way actual=%0d expected=%0d", t, vic_way, e);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      for (int s = 0; s < SETS; s++) mdl[s] = '0;
      repeat (3) @(negedge clk);
      total++;
      if (vic_vld !== 1'b0) begin
         bad++;
         $display("FAIL R1 vic_vld in reset actual=%b expected=0", vic_vld);
      end
      rst_n = 1'b1;
      idle();
      // R1: fresh sets give way 0
      ask(0, "R1"); ask(5, "R1"); ask(255, "R1");
      // R2: marked ways are skipped
      hit(3, 0); hit(3, 1); hit(3, 2); ask(3, "R2");
      hit(3, 5); ask(3, "R2");
      // R8: neighbour set untouched
      ask(4, "R8"); ask(2, "R8");
      // R4: out-of-order marking
      hit(7, 1); hit(7, 3); ask(7, "R4");
      hit(7, 0); ask(7, "R4");
      hit(7, 2); ask(7, "R4");
      // R3: completing a set clears it
      for (int w = 7; w >= 0; w--) hit(9, w);
      ask(9, "R3");
      hit(9, 0); ask(9, "R3");
      // R5: fills mark ways and can complete a set
      step(0, 0, 0, 1, 11, 0, 0, 0, ""); ask(11, "R5");
      for (int w = 1; w < WAYS; w++) step(0, 0, 0, 1, 11, w, 0, 0, "");
      ask(11, "R5");
      // R6: same-cycle ask and hit see old state
      step(1, 13, 0, 0, 0, 0, 1, 13, "R6");
      ask(13, "R6");
      step(1, 13, 1, 0, 0, 0, 1, 13, "R6");
      ask(13, "R6");
      // R9: hit and fill together
      step(1, 20, 0, 1, 20, 1, 0, 0, ""); ask(20, "R9");
      for (int w = 2; w < 6; w++) hit(20, w);
      step(1, 20, 6, 1, 20, 7, 1, 20, "R9");
      ask(20, "R9");
      // R7: idle gaps must stay quiet
      idle(); idle();
      // Mixed pseudo-random traffic over 16 sets
      lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[0], int'(lf[4:1]), int'(lf[7:5]),
              lf[8], int'(lf[12:9]), int'(lf[15:13]),
              lf[1] | lf[11], int'({lf[2], lf[6], lf[10], lf[14]}), "R4 R8 mix");
      end
      idle(); idle(); idle();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule